// File: doc/BRIEF.md
# Slow Peripheral Wait-State Generator

This block sits between a fast 8-bit processor bus and one slow peripheral that has to see its own clock at roughly the 1 MHz base rate. It decodes a 4 KB I/O window at the top nibble of the address. For any access inside that window, it holds the processor's ready line low until a full slow-clock cycle has passed. The same CPU clock is divided by a small counter to make the peripheral clock, so the slow clock stays phase-aligned with the processor. The stall always ends in the slow clock's high phase, where the peripheral samples the bus.

Software writes a 2-bit speed code that tells the block how fast the CPU clock runs relative to the base rate, and with it the divide ratio N. All state moves only on cycles where the CPU clock enable is high. The block drives the ready line, the divided clock, a chip select gated by that clock, and a read/write strobe for the peripheral.

Top module: `slowio_waitgen`

## Requirements
- R1: The window is hit when address bits [15:12] equal 4'hD. The chip select is high only when the window is hit and the divided clock is high.
- R2: A speed write (write enable high on an enabled cycle) loads code k. Code 0 gives N=1, code 1 gives N=2, code 2 gives N=4 and code 3 gives N=8.
- R3: The divider counts enabled cycles modulo N. The divided clock is high while the count is at least N/2, and is always high when N=1. A speed write restarts the count at 0.
- R4: A window access that starts at count 0 holds ready low for exactly N-1 cycles. It completes in the cycle whose count is N-1.
- R5: A window access that starts at count c>0 holds ready low for 2N-c-1 cycles, running to the end of the next whole slow cycle.
- R6: With N=1, ready stays high and no wait cycles are added.
- R7: Write accesses stall exactly like reads. The peripheral read/write strobe follows the CPU's R/W only while the chip select is high, and is high otherwise.
- R8: Ready is never low outside the window. The divided clock is high in the cycle where a window access completes.
- R9: On a cycle with the clock enable low, nothing changes: count, divided clock, speed code and pending access all hold, and a speed write on that cycle is ignored.
- R10: Reset selects N=1, clears the count and any pending access, and sets the divided clock high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU clock enable; state advances only when high |
| addr_i | input | 16 | CPU address |
| rnw_i | input | 1 | CPU read (1) / write (0) |
| spd_we_i | input | 1 | Speed code write enable |
| spd_wdata_i | input | 2 | Speed code written |
| rdy_o | output | 1 | Ready to the CPU; low inserts a wait cycle |
| pclk_o | output | 1 | Divided peripheral clock |
| pcs_o | output | 1 | Peripheral chip select |
| prnw_o | output | 1 | Peripheral read/write strobe |

## Verification
The bench uses the default parameters: a 16-bit address, a 4-bit window tag of 4'hD and a 2-bit speed code. With these, every divide ratio from 1 to 8 can be reached, which covers the 1x no-wait case, the 7-wait stretch at 8x, and the misaligned 2N-c-1 case at 2x. It also switches ratio while an access is pending, which shows the count restart. Because the counter is only three bits wide, every count value and every wrap lies within a few dozen cycles.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    localparam int WSG_ADDR_W   = 16;
    localparam int WSG_WIN_BITS = 4;
    localparam int WSG_SEL_W    = 2;

    typedef enum logic [WSG_SEL_W-1:0] {
        SPD_X1 = 2'd0,
        SPD_X2 = 2'd1,
        SPD_X4 = 2'd2,
        SPD_X8 = 2'd3
    } spd_e;

endpackage

// File: rtl/wsg_decode.sv
module wsg_decode #(
    parameter int                  ADDR_W   = 16,
    parameter int                  WIN_BITS = 4,
    parameter logic [WIN_BITS-1:0] WIN_TAG  = 4'hD
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [WIN_BITS-1:0] tag_w;

    always_comb begin
        tag_w = addr_i[ADDR_W-1 -: WIN_BITS];
        hit_o = (tag_w == WIN_TAG);
    end
endmodule

// File: rtl/wsg_divider.sv
module wsg_divider #(
    parameter int SEL_W = 2,
    localparam int CNT_W = (1 << SEL_W) - 1,
    localparam int RAT_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_i,
    input  logic             we_i,
    input  logic [SEL_W-1:0] wdata_i,
    output logic [SEL_W-1:0] sel_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             first_o,
    output logic             last_o,
    output logic             slow_o
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic             slow;
    } div_st_t;

    div_st_t     st_d, st_q;
    logic [RAT_W-1:0] ratio_now;
    logic [RAT_W-1:0] ratio_nx;

    always_comb begin
        ratio_now = RAT_W'(1) << st_q.sel;
        first_o   = (st_q.cnt == '0);
        last_o    = ({1'b0, st_q.cnt} == (ratio_now - RAT_W'(1)));

        st_d = st_q;
        if (ce_i) begin
            if (we_i) begin
                st_d.sel = wdata_i;
                st_d.cnt = '0;
            end else if (last_o) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end

        ratio_nx = RAT_W'(1) << st_d.sel;
        if (ratio_nx == RAT_W'(1)) begin
            st_d.slow = 1'b1;
        end else begin
            st_d.slow = ({1'b0, st_d.cnt} >= (ratio_nx >> 1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel  <= '0;
            st_q.cnt  <= '0;
            st_q.slow <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o  = st_q.sel;
    assign cnt_o  = st_q.cnt;
    assign slow_o = st_q.slow;
endmodule

// File: rtl/wsg_stall.sv
module wsg_stall (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_i,
    input  logic hit_i,
    input  logic first_i,
    input  logic last_i,
    input  logic clr_i,
    output logic rdy_o
);
    typedef struct packed {
        logic armed;
    } stall_st_t;

    stall_st_t st_d, st_q;
    logic      done_w;

    always_comb begin
        done_w = hit_i && last_i && (st_q.armed || first_i);
        rdy_o  = !(hit_i && !done_w);

        st_d = st_q;
        if (ce_i) begin
            if (clr_i) begin
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = hit_i && !done_w && (st_q.armed || first_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/slowio_waitgen.sv
module slowio_waitgen #(
    parameter int                  ADDR_W   = wsg_pkg::WSG_ADDR_W,
    parameter int                  WIN_BITS = wsg_pkg::WSG_WIN_BITS,
    parameter logic [WIN_BITS-1:0] WIN_TAG  = 4'hD,
    parameter int                  SEL_W    = wsg_pkg::WSG_SEL_W,
    localparam int                 CNT_W    = (1 << SEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_ce,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rnw_i,
    input  logic              spd_we_i,
    input  logic [SEL_W-1:0]  spd_wdata_i,
    output logic              rdy_o,
    output logic              pclk_o,
    output logic              pcs_o,
    output logic              prnw_o
);
    logic             hit;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_first;
    logic             cnt_last;
    logic             slow_q;

    wsg_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .WIN_TAG  (WIN_TAG)
    ) u_dec (
        .addr_i (addr_i),
        .hit_o  (hit)
    );

    wsg_divider #(
        .SEL_W (SEL_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_i    (cpu_ce),
        .we_i    (spd_we_i),
        .wdata_i (spd_wdata_i),
        .sel_o   (sel_q),
        .cnt_o   (cnt_q),
        .first_o (cnt_first),
        .last_o  (cnt_last),
        .slow_o  (slow_q)
    );

    wsg_stall u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_i    (cpu_ce),
        .hit_i   (hit),
        .first_i (cnt_first),
        .last_i  (cnt_last),
        .clr_i   (spd_we_i),
        .rdy_o   (rdy_o)
    );

    always_comb begin
        pclk_o = slow_q;
        pcs_o  = hit && slow_q;
        prnw_o = pcs_o ? rnw_i : 1'b1;
    end
endmodule

// File: rtl/slowio_waitgen_chk.sv
module slowio_waitgen_chk #(
    parameter int                  ADDR_W   = 16,
    parameter int                  WIN_BITS = 4,
    parameter logic [WIN_BITS-1:0] WIN_TAG  = 4'hD,
    parameter int                  SEL_W    = 2,
    localparam int                 CNT_W    = (1 << SEL_W) - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ce,
    input logic [ADDR_W-1:0] addr_i,
    input logic              spd_we_i,
    input logic [SEL_W-1:0]  spd_wdata_i,
    input logic              rdy_o,
    input logic              pclk_o,
    input logic              pcs_o,
    input logic [SEL_W-1:0]  sel_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              cnt_last
);
    logic in_win;
    assign in_win = (addr_i[ADDR_W-1 -: WIN_BITS] == WIN_TAG);

    // R1
    cs_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcs_o |-> pclk_o);

    // R8
    rdy_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> rdy_o);

    // R8
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && rdy_o) |-> pclk_o);

    // R6
    full_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |-> rdy_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ce |=> ($stable(pclk_o) && $stable(sel_q) && $stable(cnt_q)));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && !spd_we_i && cnt_last) |=> (cnt_q == '0));

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && spd_we_i) |=> ((sel_q == $past(spd_wdata_i)) && (cnt_q == '0)));
endmodule

bind slowio_waitgen slowio_waitgen_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .WIN_TAG  (WIN_TAG),
    .SEL_W    (SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_ce      (cpu_ce),
    .addr_i      (addr_i),
    .spd_we_i    (spd_we_i),
    .spd_wdata_i (spd_wdata_i),
    .rdy_o       (rdy_o),
    .pclk_o      (pclk_o),
    .pcs_o       (pcs_o),
    .sel_q       (sel_q),
    .cnt_q       (cnt_q),
    .cnt_last    (cnt_last)
);

// File: tb/tb_slowio_waitgen.sv
module tb_slowio_waitgen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_ce;
    logic [15:0] addr_i;
    logic        rnw_i;
    logic        spd_we_i;
    logic [1:0]  spd_wdata_i;
    logic        rdy_o, pclk_o, pcs_o, prnw_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    slowio_waitgen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_ce      (cpu_ce),
        .addr_i      (addr_i),
        .rnw_i       (rnw_i),
        .spd_we_i    (spd_we_i),
        .spd_wdata_i (spd_wdata_i),
        .rdy_o       (rdy_o),
        .pclk_o      (pclk_o),
        .pcs_o       (pcs_o),
        .prnw_o      (prnw_o)
    );

    // row: ce, we, wdata, addr, rnw | exp rdy, cs, pclk, prnw
    localparam int NROWS = 34;
    localparam logic [24:0] VEC [0:NROWS-1] = '{
        {1'b1,1'b0,2'd0,16'h1234,1'b1, 4'b1011},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b1111},
        {1'b1,1'b0,2'd0,16'hD400,1'b0, 4'b1110},
        {1'b1,1'b1,2'd1,16'h0200,1'b1, 4'b1011},
        {1'b1,1'b0,2'd0,16'hD010,1'b1, 4'b0001},
        {1'b1,1'b0,2'd0,16'hD010,1'b1, 4'b1111},
        {1'b1,1'b0,2'd0,16'hD010,1'b1, 4'b0001},
        {1'b1,1'b0,2'd0,16'h3000,1'b1, 4'b1011},
        {1'b1,1'b0,2'd0,16'h3000,1'b1, 4'b1001},
        {1'b1,1'b0,2'd0,16'hDFFF,1'b0, 4'b0110},
        {1'b1,1'b0,2'd0,16'hDFFF,1'b0, 4'b0001},
        {1'b1,1'b0,2'd0,16'hDFFF,1'b0, 4'b1110},
        {1'b0,1'b0,2'd0,16'hDFFF,1'b0, 4'b0001},
        {1'b0,1'b1,2'd3,16'hDFFF,1'b0, 4'b0001},
        {1'b1,1'b0,2'd0,16'hDFFF,1'b0, 4'b0001},
        {1'b1,1'b0,2'd0,16'hDFFF,1'b0, 4'b1110},
        {1'b1,1'b1,2'd3,16'h0000,1'b1, 4'b1001},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b0001},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b0001},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b0001},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b0001},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b0111},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b0111},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b0111},
        {1'b1,1'b0,2'd0,16'hD000,1'b1, 4'b1111},
        {1'b1,1'b0,2'd0,16'h0400,1'b1, 4'b1001},
        {1'b1,1'b1,2'd2,16'h0400,1'b1, 4'b1001},
        {1'b1,1'b0,2'd0,16'hD800,1'b1, 4'b0001},
        {1'b1,1'b0,2'd0,16'hD800,1'b1, 4'b0001},
        {1'b1,1'b0,2'd0,16'hD800,1'b1, 4'b0111},
        {1'b1,1'b0,2'd0,16'hD800,1'b1, 4'b1111},
        {1'b1,1'b0,2'd0,16'hCFFF,1'b1, 4'b1001},
        {1'b1,1'b0,2'd0,16'hE000,1'b1, 4'b1001},
        {1'b1,1'b0,2'd0,16'h0100,1'b1, 4'b1011}
    };

    function automatic string row_tag(int i);
        if (i < 3)       return "R6";
        else if (i == 3) return "R2";
        else if (i < 9)  return "R4";
        else if (i < 12) return "R5";
        else if (i < 16) return "R9";
        else if (i == 16) return "R2";
        else if (i < 25) return "R4";
        else if (i < 27) return "R3";
        else if (i < 31) return "R2";
        else if (i < 33) return "R1";
        else             return "R3";
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic drive(logic ce, logic we, logic [1:0] wd, logic [15:0] a, logic rw);
        cpu_ce      = ce;
        spd_we_i    = we;
        spd_wdata_i = wd;
        addr_i      = a;
        rnw_i       = rw;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 2'd0, 16'h0000, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R10 reset state
        chk("R10", "reset rdy",  rdy_o,  1'b1);
        chk("R10", "reset pclk", pclk_o, 1'b1);
        chk("R10", "reset cs",   pcs_o,  1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            drive(VEC[i][24], VEC[i][23], VEC[i][22:21], VEC[i][20:5], VEC[i][4]);
            #1;
            chk(row_tag(i), $sformatf("row %0d rdy", i), rdy_o, VEC[i][3]);
            chk("R1", $sformatf("row %0d cs", i), pcs_o, VEC[i][2]);
            chk("R3", $sformatf("row %0d pclk", i), pclk_o, VEC[i][1]);
            chk("R7", $sformatf("row %0d prnw", i), prnw_o, VEC[i][0]);
        end

        // Now N=4, count 3: misaligned access, then speed write mid-access
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd0, 16'hD000, 1'b1);
        #1;
        chk("R5", "misaligned at last count rdy", rdy_o, 1'b0);
        @(negedge clk);
        drive(1'b1, 1'b1, 2'd1, 16'hD000, 1'b1);
        #1;
        chk("R3", "speed write cycle rdy", rdy_o, 1'b0);
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd0, 16'hD000, 1'b1);
        #1;
        chk("R3", "restart count 0 rdy", rdy_o, 1'b0);
        chk("R3", "restart count 0 pclk", pclk_o, 1'b0);
        @(negedge clk);
        #1;
        chk("R4", "after restart release rdy", rdy_o, 1'b1);
        chk("R8", "release in high phase", pclk_o, 1'b1);

        // Reset while an access is pending at 2x
        @(negedge clk);
        #1;
        chk("R4", "next access stalls", rdy_o, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R10", "reset mid-access rdy", rdy_o, 1'b1);
        chk("R10", "reset mid-access pclk", pclk_o, 1'b1);
        chk("R10", "reset mid-access cs", pcs_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R6", "1x after reset rdy", rdy_o, 1'b1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule